// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit Slip

This block turns a single-bit serial stream into four-bit parallel words in one clock domain. It takes its serial bit from one of two inputs on every clock edge and shifts it through a four-stage register. It loads the register into a held parallel output word at each word boundary. The bit that arrives first in a word ends up on bit 0 of the output. The serial bit that leaves the far end of the shift chain is driven on a pass-through output, so a second converter can take it as its serial input.

A modulo-8 phase counter marks the word boundaries. It produces two clock-enable strobes: one every fourth clock and one every eighth clock. The eighth-clock strobe always coincides with every other fourth-clock strobe. A width input selects the update period. When low, the output word reloads every four clocks. When high, it reloads every eight clocks, so two chained converters can together present an eight-bit word.

A slip input realigns the word boundary. Each rising edge on the slip input passes through a two-flop synchronizer and an edge detector. It then holds the phase counter for exactly one clock. This moves every later bit one position toward bit 0 of the word. A synchronous reset puts the counter and all registers at a known phase, so several converters start aligned on the same clock.

Top module: `deser_top`

## Requirements
- R1: With a fixed phase and width low, the word loaded at a boundary holds the four bits sampled on the last four edges: the oldest on bit 0 and the newest on bit 3.
- R2: When `pick_a` is 1 the bit sampled is `ser_a`; when 0 it is `ser_b`. The input not picked has no effect on the word or on `ser_out`.
- R3: With `wide` low the word reloads on edges where the counter's low two bits are 3, and it holds its value on all other edges.
- R4: With `wide` high the word reloads only on edges where the counter is 7, and it holds its value on all other edges.
- R5: `stb4` is high for the one cycle after each reloading edge where the counter's low two bits are 3. `stb8` is high only after edges where the counter is 7, so `stb8` implies `stb4`.
- R6: If `slip` is sampled 1 at edge e and was 0 at edge e-1, the counter holds its value at edge e+2 instead of advancing, and neither strobe nor a reload happens at that edge.
- R7: While `slip` stays high it causes no further holds. Each additional one-bit shift needs a new low-to-high transition.
- R8: After each edge, `ser_out` equals the bit sampled three edges earlier (0 for edges before that since reset).
- R9: An edge with `rst` high sets the counter to 0 and clears the word, the strobes, the shift chain and the slip synchronizer. The first edge after reset samples the bit that lands at counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_a | input | 1 | Serial data input, taken when `pick_a` is 1 |
| ser_b | input | 1 | Serial data input, taken when `pick_a` is 0 |
| pick_a | input | 1 | Serial input select |
| wide | input | 1 | 0: reload every 4 clocks; 1: reload every 8 clocks |
| slip | input | 1 | Bit-slip request; each rising edge holds the counter once |
| word | output | 4 | Registered parallel word, bit 0 the first bit received |
| stb4 | output | 1 | One-cycle strobe every fourth clock |
| stb8 | output | 1 | One-cycle strobe every eighth clock |
| ser_out | output | 1 | Serial bit leaving the end of the shift chain |

## Verification
The assertions assume that `slip` is a level that is already stable with respect to the clock at the synchronizer input. They also assume that `wide` changes only between bursts. The stimulus drives all inputs on the falling clock edge. It holds `wide` constant for blocks of 40 or more cycles. It shapes slip activity as pulses of two to four cycles separated by gaps, plus one long held level. Serial data, input select and the unpicked input are drawn at random from a fixed seed.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic {
    SPAN_NARROW = 1'b0,
    SPAN_WIDE   = 1'b1
  } span_e;
endpackage

// File: rtl/deser_sync_edge.sv
module deser_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise_o
);
  logic [STAGES-1:0] pipe_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], level_in};
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~last_q;

  // R7: a detected rise never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_a,
  input  logic             ser_b,
  input  logic             pick_a,
  output logic [LANES-1:0] chain_nxt,
  output logic             thru_o
);
  logic [LANES-1:0] chain_q;
  logic             bit_in;

  assign bit_in = pick_a ? ser_a : ser_b;

  for (genvar g = 0; g < LANES; g++) begin : g_stage
    if (g == LANES-1) begin : g_head
      assign chain_nxt[g] = bit_in;
    end else begin : g_body
      assign chain_nxt[g] = chain_q[g+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= chain_nxt;
  end

  assign thru_o = chain_q[0];
endmodule

// File: rtl/deser_phase.sv
module deser_phase
  import deser_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  span_e span,
  output logic  load_o,
  output logic  hit4_o,
  output logic  hit8_o
);
  localparam int CW = $clog2(2*LANES);
  logic [CW-1:0] cnt_q;
  logic          quarter, full;

  assign quarter = &cnt_q[CW-2:0];
  assign full    = &cnt_q;
  assign hit4_o  = quarter & ~hold;
  assign hit8_o  = full & ~hold;
  assign load_o  = (span == SPAN_WIDE) ? hit8_o : hit4_o;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (!hold) cnt_q <= cnt_q + 1'b1;
  end

  // R6: a slip request freezes the counter for that edge
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cnt_q));
  // R5: without a slip the counter advances by one
  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/deser_top.sv
module deser_top
  import deser_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_a,
  input  logic             ser_b,
  input  logic             pick_a,
  input  logic             wide,
  input  logic             slip,
  output logic [LANES-1:0] word,
  output logic             stb4,
  output logic             stb8,
  output logic             ser_out
);
  logic [LANES-1:0] chain_nxt;
  logic             slip_req, load, hit4, hit8;
  span_e            span;

  assign span = wide ? SPAN_WIDE : SPAN_NARROW;

  deser_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .level_in(slip), .rise_o(slip_req));

  deser_shift #(.LANES(LANES)) u_shift (
    .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b), .pick_a(pick_a),
    .chain_nxt(chain_nxt), .thru_o(ser_out));

  deser_phase #(.LANES(LANES)) u_phase (
    .clk(clk), .rst(rst), .hold(slip_req), .span(span),
    .load_o(load), .hit4_o(hit4), .hit8_o(hit8));

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      stb4 <= 1'b0;
      stb8 <= 1'b0;
    end else begin
      if (load) word <= chain_nxt;
      stb4 <= hit4;
      stb8 <= hit8;
    end
  end

  // R3/R4: the word holds between loads
  a_r3_word_holds: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word));
  // R5: the eighth-clock strobe coincides with a fourth-clock strobe
  a_r5_stb8_in_stb4: assert property (@(posedge clk) disable iff (rst)
    stb8 |-> stb4);
  // R6: no strobe on the edge a slip is applied
  a_r6_no_strobe_on_slip: assert property (@(posedge clk) disable iff (rst)
    slip_req |=> !stb4);
endmodule

// File: tb/deser_top_tb.sv
module deser_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_a = 1'b0, ser_b = 1'b0, pick_a = 1'b1, wide = 1'b0, slip = 1'b0;
  logic [3:0] word;
  logic       stb4, stb8, ser_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [2:0] m_cnt = '0;
  logic [3:0] m_hist = '0;     // m_hist[3] newest
  logic [3:0] m_word = '0;
  logic       m_s4 = 0, m_s8 = 0;
  logic [2:0] m_sy = '0;       // m_sy[0] sync at previous edge
  string      wtag = "R1";

  always #2.5 clk = ~clk;

  deser_top u_dut (.clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b),
    .pick_a(pick_a), .wide(wide), .slip(slip), .word(word), .stb4(stb4),
    .stb8(stb8), .ser_out(ser_out));

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic slip_at_edge(logic [2:0] sy);
    return sy[1] && !sy[2];   // sync high two edges ago, low three ago
  endfunction

  task automatic step();
    logic b, sl, ld;
    @(posedge clk);
    if (rst) begin
      m_cnt = 0; m_hist = 0; m_word = 0; m_s4 = 0; m_s8 = 0; m_sy = 0;
    end else begin
      b  = pick_a ? ser_a : ser_b;
      sl = slip_at_edge(m_sy);
      m_hist = {b, m_hist[3:1]};
      m_s4 = !sl && (m_cnt[1:0] == 2'd3);
      m_s8 = !sl && (m_cnt == 3'd7);
      ld = wide ? m_s8 : m_s4;
      if (ld) m_word = m_hist;
      if (!sl) m_cnt = m_cnt + 1'b1;
      m_sy = {m_sy[1:0], slip};
    end
    @(negedge clk);
    check(rst ? "R9" : wtag, word, m_word);
    check("R5", {3'b0, stb4}, {3'b0, m_s4});
    check("R5", {3'b0, stb8}, {3'b0, m_s8});
    check("R8", {3'b0, ser_out}, {3'b0, m_hist[0]});
  endtask

  task automatic rnd_data();
    ser_a = 1'($urandom); ser_b = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    repeat (2) step();                       // R9 reset state
    rst = 0;
    wtag = "R1"; pick_a = 1;
    for (int i = 0; i < 32; i++) begin ser_a = 1'(i % 3 == 0); ser_b = 1'($urandom); step(); end
    wtag = "R2"; pick_a = 0;
    for (int i = 0; i < 32; i++) begin rnd_data(); step(); end
    for (int i = 0; i < 32; i++) begin pick_a = 1'($urandom); rnd_data(); step(); end
    wtag = "R6";
    for (int k = 0; k < 6; k++) begin
      slip = 1; repeat (2 + k % 3) begin rnd_data(); step(); end
      slip = 0; repeat (9) begin rnd_data(); step(); end
    end
    wtag = "R7"; slip = 1;
    for (int i = 0; i < 40; i++) begin rnd_data(); step(); end
    slip = 0;
    wtag = "R4"; wide = 1;
    for (int i = 0; i < 48; i++) begin rnd_data(); slip = (i % 16 == 3) || (i % 16 == 4); step(); end
    wtag = "R9"; rst = 1; step(); rst = 0;
    for (int i = 0; i < 12; i++) begin rnd_data(); step(); end
    wtag = "R3";
    for (int blk = 0; blk < 30; blk++) begin
      wide = 1'($urandom);
      for (int i = 0; i < 40; i++) begin
        pick_a = 1'($urandom); rnd_data();
        slip = ((i % 13) == 5 || (i % 13) == 6) && blk[0];
        step();
      end
    end
    slip = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); n_chk++; n_fail++;
        $display("FAIL watchdog R9 got=hung exp=done"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule